// File: doc/BRIEF.md
# Vertical Segment Alternation Sequencer

This block drives one vertical clock line of an image-sensor timing generator. The per-line waveform is built by playing a list of short segments back to back. Every segment has the same length. Each segment is drawn from one of four groups, and each group holds up to four enabled toggle offsets. The order of groups comes from two select vectors. For each slot, one bit of each vector forms a 2-bit group code, so any group can follow any other. A second pair of select vectors serves odd lines, which lets the sequence change with line parity.

When alternation is off, the block plays group A only. It can also run a merged mode in which the toggles of all four groups act together inside each group-A-length segment. A line-start strobe latches the whole configuration. Playback begins after a programmable delay and runs for the programmed number of slots. The line then rests at the start polarity until the next strobe.

Top module: `vseg_alt_seq`

## Requirements
- R1: After reset `vclk` and `busy` are 0. Whenever no pattern is playing, `busy` is 0 and `vclk` equals the start polarity latched at the last strobe.
- R2: With latched delay D, the first pattern cycle appears on `vclk` after the (D+1)-th rising edge following the edge that samples `lineStart`. `busy` is 1 for exactly count × length cycles, and those cycles line up with the pattern.
- R3: At offset p (0-based) inside a segment, `vclk` equals the start polarity XOR the parity of the number of enabled toggles of that segment's group whose offset is at most p. Each segment restarts from the start polarity, and offsets at or beyond the segment length never act.
- R4: With `altEn`=1, slot i plays the group whose code is {sel1[i], sel0[i]}: 0 gives A, 1 gives B, 2 gives C, 3 gives D. `catEn` is ignored in this mode.
- R5: `lineOdd`=1 at the strobe selects the odd select vectors. `lineOdd`=0 selects the even ones.
- R6: With `altEn`=0 and `catEn`=0, every slot plays group A.
- R7: With `altEn`=0 and `catEn`=1, all sixteen toggles act in every segment under the R3 parity rule, so two enabled toggles at the same offset cancel.
- R8: A slot count of 0 is played as 1 and a count above 18 is played as 18. A segment length of 0 is played as 1.
- R9: Configuration inputs are sampled only on the strobe edge. Changes made during a line do not alter that line.
- R10: A strobe that arrives during a line abandons it and starts the new line with the R2 timing.
- Flat layout: toggle t (0..3) of group g (0=A..3=D) sits at index k=4g+t. Its offset is `togglePos[k*LEN_W +: LEN_W]` and its enable is `toggleEn[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStart | input | 1 | Line-start strobe, one cycle |
| lineOdd | input | 1 | Line parity, 1 = odd line |
| altEn | input | 1 | Enables segment alternation |
| catEn | input | 1 | Enables merged-toggle mode |
| startPol | input | 1 | Level at the start of each segment |
| segLen | input | LEN_W | Segment length in clocks |
| segCount | input | 5 | Number of slots to play |
| startDelay | input | DLY_W | Clocks from strobe to first slot |
| selEven0 | input | 18 | Even-line select vector, low code bit |
| selEven1 | input | 18 | Even-line select vector, high code bit |
| selOdd0 | input | 18 | Odd-line select vector, low code bit |
| selOdd1 | input | 18 | Odd-line select vector, high code bit |
| togglePos | input | 16*LEN_W | Toggle offsets, flat |
| toggleEn | input | 16 | Toggle enables |
| vclk | output | 1 | Vertical clock level |
| busy | output | 1 | High while a pattern plays |

## Verification
The bench keeps the default widths: LEN_W=6, so segments run up to 63 clocks, and DLY_W=4, so delays run up to 15 clocks. With short segment lengths of 1 to 5 clocks, a full 18-slot line, a clamped count of 25, a zero-length segment and toggle offsets past the segment end all fit in a few hundred cycles. The 6-bit offsets also allow a toggle at offset 63, which can never match. The largest delay is short enough that the wait phase can be checked one cycle at a time.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  localparam int MAX_SLOTS = 18;
  localparam int CNT_W     = $clog2(MAX_SLOTS + 1);
  localparam int SLOT_W    = CNT_W;
  localparam int NUM_GRP   = 4;
  localparam int NUM_TGL   = 4;
  localparam int NUM_TOG   = NUM_GRP * NUM_TGL;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} seqState_t;

  typedef struct packed {
    logic load;
    logic run;
    logic segStart;
  } ctrlStrobe_t;

  function automatic logic [CNT_W-1:0] clampCount(input logic [CNT_W-1:0] c);
    if (c == '0) return CNT_W'(1);
    else if (c > CNT_W'(MAX_SLOTS)) return CNT_W'(MAX_SLOTS);
    else return c;
  endfunction
endpackage

// File: rtl/vsa_ctrl.sv
module vsa_ctrl
  import vsa_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int DLY_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic [LEN_W-1:0]  segLenIn,
  input  logic [CNT_W-1:0]  segCountIn,
  input  logic [DLY_W-1:0]  startDelayIn,
  output ctrlStrobe_t       strobe,
  output logic [LEN_W-1:0]  pos,
  output logic [SLOT_W-1:0] slot
);
  seqState_t         state;
  logic [LEN_W-1:0]  lenQ;
  logic [CNT_W-1:0]  countQ;
  logic [DLY_W-1:0]  dlyCnt;
  logic              lastPos;
  logic              lastSlot;

  assign lastPos  = (pos == lenQ - LEN_W'(1));
  assign lastSlot = (slot == countQ - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      lenQ   <= LEN_W'(1);
      countQ <= CNT_W'(1);
      dlyCnt <= '0;
      pos    <= '0;
      slot   <= '0;
    end else if (lineStart) begin
      lenQ   <= (segLenIn == '0) ? LEN_W'(1) : segLenIn;
      countQ <= clampCount(segCountIn);
      pos    <= '0;
      slot   <= '0;
      if (startDelayIn == '0) begin
        state <= ST_RUN;
      end else begin
        state  <= ST_WAIT;
        dlyCnt <= startDelayIn;
      end
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (dlyCnt == DLY_W'(1)) state <= ST_RUN;
          else dlyCnt <= dlyCnt - DLY_W'(1);
        end
        ST_RUN: begin
          if (lastPos) begin
            pos <= '0;
            if (lastSlot) state <= ST_IDLE;
            else slot <= slot + SLOT_W'(1);
          end else begin
            pos <= pos + LEN_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.load     = lineStart;
    strobe.run      = (state == ST_RUN);
    strobe.segStart = (state == ST_RUN) && (pos == '0);
  end

  assert_slot_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (slot < countQ && countQ >= CNT_W'(1) && countQ <= CNT_W'(MAX_SLOTS)));

  assert_pos_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (pos < lenQ));

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> (state != ST_IDLE));

  assert_wait_expiry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && dlyCnt == DLY_W'(1) && !lineStart) |=>
      (state == ST_RUN && pos == '0 && slot == '0));
endmodule

// File: rtl/vsa_datapath.sv
module vsa_datapath
  import vsa_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [LEN_W-1:0]         pos,
  input  logic [SLOT_W-1:0]        slot,
  input  logic                     altEnIn,
  input  logic                     catEnIn,
  input  logic                     startPolIn,
  input  logic                     lineOddIn,
  input  logic [MAX_SLOTS-1:0]     selEven0In,
  input  logic [MAX_SLOTS-1:0]     selEven1In,
  input  logic [MAX_SLOTS-1:0]     selOdd0In,
  input  logic [MAX_SLOTS-1:0]     selOdd1In,
  input  logic [NUM_TOG*LEN_W-1:0] togglePosIn,
  input  logic [NUM_TOG-1:0]       toggleEnIn,
  output logic                     vclk,
  output logic                     busy
);
  logic                     altQ, catQ, polQ;
  logic [MAX_SLOTS-1:0]     sel0Q, sel1Q;
  logic [NUM_TOG*LEN_W-1:0] tPosQ;
  logic [NUM_TOG-1:0]       tEnQ;
  logic [NUM_TOG-1:0]       tglHit;
  logic [NUM_GRP-1:0]       grpParity;
  logic [1:0]               grpCode;
  logic                     hit;
  logic                     levelQ, lvlNext, busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      altQ  <= 1'b0;
      catQ  <= 1'b0;
      polQ  <= 1'b0;
      sel0Q <= '0;
      sel1Q <= '0;
      tPosQ <= '0;
      tEnQ  <= '0;
    end else if (strobe.load) begin
      altQ  <= altEnIn;
      catQ  <= catEnIn;
      polQ  <= startPolIn;
      sel0Q <= lineOddIn ? selOdd0In : selEven0In;
      sel1Q <= lineOddIn ? selOdd1In : selEven1In;
      tPosQ <= togglePosIn;
      tEnQ  <= toggleEnIn;
    end
  end

  for (genvar k = 0; k < NUM_TOG; k++) begin : g_match
    assign tglHit[k] = tEnQ[k] && (tPosQ[k*LEN_W +: LEN_W] == pos);
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_group
    assign grpParity[g] = ^tglHit[g*NUM_TGL +: NUM_TGL];
  end

  always_comb begin
    grpCode = altQ ? {sel1Q[slot], sel0Q[slot]} : 2'd0;
    if (!altQ && catQ) hit = ^tglHit;
    else hit = grpParity[grpCode];
    lvlNext = (strobe.segStart ? polQ : levelQ) ^ hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= 1'b0;
      busyQ  <= 1'b0;
    end else begin
      levelQ <= strobe.run ? lvlNext : polQ;
      busyQ  <= strobe.run;
    end
  end

  assign vclk = levelQ;
  assign busy = busyQ;

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && !$past(strobe.load)) |-> (vclk == polQ));

  assert_busy_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(strobe.segStart));
endmodule

// File: rtl/vseg_alt_seq.sv
module vseg_alt_seq
  import vsa_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int DLY_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lineStart,
  input  logic                     lineOdd,
  input  logic                     altEn,
  input  logic                     catEn,
  input  logic                     startPol,
  input  logic [LEN_W-1:0]         segLen,
  input  logic [CNT_W-1:0]         segCount,
  input  logic [DLY_W-1:0]         startDelay,
  input  logic [MAX_SLOTS-1:0]     selEven0,
  input  logic [MAX_SLOTS-1:0]     selEven1,
  input  logic [MAX_SLOTS-1:0]     selOdd0,
  input  logic [MAX_SLOTS-1:0]     selOdd1,
  input  logic [NUM_TOG*LEN_W-1:0] togglePos,
  input  logic [NUM_TOG-1:0]       toggleEn,
  output logic                     vclk,
  output logic                     busy
);
  ctrlStrobe_t       strobe;
  logic [LEN_W-1:0]  pos;
  logic [SLOT_W-1:0] slot;

  vsa_ctrl #(.LEN_W(LEN_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart),
    .segLenIn(segLen), .segCountIn(segCount), .startDelayIn(startDelay),
    .strobe(strobe), .pos(pos), .slot(slot)
  );

  vsa_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pos(pos), .slot(slot),
    .altEnIn(altEn), .catEnIn(catEn), .startPolIn(startPol), .lineOddIn(lineOdd),
    .selEven0In(selEven0), .selEven1In(selEven1),
    .selOdd0In(selOdd0), .selOdd1In(selOdd1),
    .togglePosIn(togglePos), .toggleEnIn(toggleEn),
    .vclk(vclk), .busy(busy)
  );
endmodule

// File: tb/sim_vseg_alt_seq.sv
module sim_vseg_alt_seq;
  localparam int LW = 6;
  localparam int DW = 4;

  logic clk = 1'b0, rstN = 1'b0, lineStart = 1'b0, lineOdd = 1'b0;
  logic altEn = 1'b0, catEn = 1'b0, startPol = 1'b0;
  logic [LW-1:0] segLen = '0;
  logic [4:0] segCount = '0;
  logic [DW-1:0] startDelay = '0;
  logic [17:0] selEven0 = '0, selEven1 = '0, selOdd0 = '0, selOdd1 = '0;
  logic [16*LW-1:0] togglePos = '0;
  logic [15:0] toggleEn = '0;
  logic vclk, busy;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vseg_alt_seq #(.LEN_W(LW), .DLY_W(DW)) u0 (.*);

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic clearTogs();
    togglePos = '0;
    toggleEn = '0;
  endtask

  task automatic setTog(input int g, input int t, input int p);
    togglePos[(g*4+t)*LW +: LW] = LW'(p);
    toggleEn[g*4+t] = 1'b1;
  endtask

  task automatic setSlot(input bit odd, input int i, input int code);
    if (odd) begin selOdd0[i] = code[0]; selOdd1[i] = code[1]; end
    else begin selEven0[i] = code[0]; selEven1[i] = code[1]; end
  endtask

  // Plays one line and compares every cycle against a model of the requirements.
  task automatic playLine(input string tag, input int corruptAt);
    bit sAlt = altEn, sCat = catEn, sPol = startPol;
    logic [17:0] s0 = lineOdd ? selOdd0 : selEven0;
    logic [17:0] s1 = lineOdd ? selOdd1 : selEven1;
    logic [16*LW-1:0] sPos = togglePos;
    logic [15:0] sEn = toggleEn;
    int sLen = (segLen == 0) ? 1 : int'(segLen);
    int sCnt = (segCount == 0) ? 1 : (segCount > 18 ? 18 : int'(segCount));
    int sDly = int'(startDelay);
    int total = sCnt * sLen;
    @(negedge clk);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    for (int k = 1; k <= sDly + total + 1; k++) begin
      @(negedge clk);
      if (k <= sDly || k == sDly + total + 1) begin
        checkBit(tag, "idle vclk", vclk, sPol);
        checkBit(tag, "idle busy", busy, 1'b0);
      end else begin
        int idx = k - sDly - 1;
        int sl = idx / sLen;
        int p = idx % sLen;
        int g = sAlt ? int'({s1[sl], s0[sl]}) : 0;
        logic lv = sPol;
        for (int i = 0; i < 16; i++) begin
          bit inScope = (sCat && !sAlt) || (i / 4 == g);
          if (inScope && sEn[i] && int'(sPos[i*LW +: LW]) <= p) lv = ~lv;
        end
        checkBit(tag, $sformatf("vclk slot%0d pos%0d", sl, p), vclk, lv);
        checkBit(tag, "busy", busy, 1'b1);
      end
      if (k == corruptAt) begin
        toggleEn = ~toggleEn; startPol = ~startPol; altEn = ~altEn;
        selEven0 = ~selEven0; selOdd1 = ~selOdd1; segCount = 5'd3;
        segLen = segLen + 1'b1; startDelay = 4'd5;
      end
    end
  endtask

  task automatic baseCfg(input int len, input int cnt, input int dly, input bit pol);
    altEn = 0; catEn = 0; startPol = pol; lineOdd = 0;
    segLen = LW'(len); segCount = 5'(cnt); startDelay = DW'(dly);
    selEven0 = '0; selEven1 = '0; selOdd0 = '0; selOdd1 = '0;
    clearTogs();
  endtask

  task automatic testReset();
    checkBit("R1", "reset vclk", vclk, 1'b0);
    checkBit("R1", "reset busy", busy, 1'b0);
  endtask

  task automatic testPlainA();
    baseCfg(4, 2, 0, 0);
    setTog(0, 0, 1); setTog(0, 1, 3); setTog(1, 0, 2);
    playLine("R6_plainA", -1);
  endtask

  task automatic loadGroups();
    clearTogs();
    setTog(0, 0, 1);
    setTog(1, 0, 0); setTog(1, 1, 2);
    setTog(2, 0, 3);
    setTog(3, 0, 1); setTog(3, 1, 2); setTog(3, 2, 4);
  endtask

  task automatic testAltEven();
    int codes[6] = '{3, 1, 2, 0, 3, 2};
    baseCfg(5, 6, 0, 0);
    loadGroups();
    altEn = 1; catEn = 1;
    foreach (codes[i]) begin setSlot(0, i, codes[i]); setSlot(1, i, 3 - codes[i]); end
    playLine("R4_altEven", -1);
  endtask

  task automatic testAltOdd();
    lineOdd = 1;
    playLine("R5_altOdd", -1);
    selOdd0 = selEven0; selOdd1 = selEven1;
    playLine("R5_oddSame", -1);
  endtask

  task automatic testDelayPol();
    baseCfg(3, 3, 7, 1);
    setTog(0, 0, 0); setTog(0, 1, 2);
    playLine("R2_delay", -1);
    startDelay = DW'(15);
    playLine("R2_delayMax", -1);
  endtask

  task automatic testClamp();
    baseCfg(2, 0, 0, 0);
    setTog(0, 0, 1);
    playLine("R8_cnt0", -1);
    altEn = 1;
    for (int i = 0; i < 18; i++) setSlot(0, i, i % 4);
    setTog(1, 0, 0); setTog(2, 0, 1); setTog(3, 0, 0); setTog(3, 1, 1);
    segCount = 5'd25;
    playLine("R8_cnt25", -1);
    segCount = 5'd18;
    playLine("R8_cnt18", -1);
    segLen = '0; segCount = 5'd3;
    playLine("R8_len0", -1);
  endtask

  task automatic testRange();
    baseCfg(4, 2, 1, 0);
    setTog(0, 0, 5); setTog(0, 1, 63); setTog(0, 2, 2); setTog(0, 3, 4);
    playLine("R3_range", -1);
  endtask

  task automatic testConcat();
    baseCfg(5, 2, 0, 1);
    catEn = 1;
    setTog(0, 0, 2); setTog(2, 0, 2); setTog(1, 0, 1); setTog(3, 3, 4);
    playLine("R7_concat", -1);
  endtask

  task automatic testMidLine();
    baseCfg(4, 4, 2, 0);
    loadGroups();
    altEn = 1;
    for (int i = 0; i < 4; i++) setSlot(0, i, 3 - i);
    playLine("R9_midline", 3);
  endtask

  task automatic testRestart();
    baseCfg(6, 5, 0, 0);
    setTog(0, 0, 1);
    @(negedge clk); lineStart = 1'b1;
    @(negedge clk); lineStart = 1'b0;
    repeat (9) @(negedge clk);
    startDelay = DW'(2); startPol = 1;
    playLine("R10_restart", -1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checkBit("R1_hold", "vclk", vclk, 1'b1);
      checkBit("R1_hold", "busy", busy, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlainA();
    testAltEven();
    testAltOdd();
    testDelayPol();
    testClamp();
    testRange();
    testConcat();
    testMidLine();
    testRestart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule